// File: doc/BRIEF.md
# External Interrupt Sense and Latch

This block is the front end that turns raw interrupt pins into clean requests for a parent interrupt controller. It serves one non-maskable input and sixteen general interrupt pins. Each pin first goes through a two-flop synchronizer. A programmable sense detector then watches the synchronized value and sets a per-source status flag. Every flag drives a request line that is active high as a level.

Software reaches the block through a simple 32-bit register bus. It selects the sense mode of each source, reads the status flags and clears latched flags by writing ones. The general pins can be sensed on a low level, a falling edge, a rising edge or both edges. The non-maskable input can only be sensed on an edge. Flags on level-sensed pins follow the pin and clear when it returns high. Flags on edge-sensed pins stay set until software clears them.

Top module: `ext_irq_sense`

## Requirements
- R1: After reset every sense selection is 0, every status flag is clear and every request output is low.
- R2: The register map is: non-maskable status at 0x00 (bit 0), non-maskable clear at 0x04, non-maskable sense at 0x08 (bit 0), pin status at 0x10 (bit n for pin n), pin clear at 0x14, and pin sense at 0x18. The sense registers read back what was written. The clear registers read as zero.
- R3: Non-maskable sense value 0 latches the flag on a falling edge and value 1 latches it on a rising edge. An edge of the other direction leaves the flag unchanged.
- R4: Writing 1 to bit 0 at offset 0x04 clears the non-maskable flag.
- R5: Pin n takes its sense mode from bits [2n+1:2n] at offset 0x18. The codes are 0 for low level, 1 for falling edge, 2 for rising edge and 3 for both edges.
- R6: In low-level mode the flag is set while the synchronized pin is low and clears by itself once the pin is high. A 1 written to that bit at 0x14 leaves the flag unchanged.
- R7: In an edge mode the flag latches on the selected edge and holds until a 1 is written to bit n at 0x14. An edge of a direction that is not selected does not set the flag.
- R8: When an edge is detected in the same cycle as a clear write to that bit, the flag remains set.
- R9: Changing a sense field does not by itself set a flag.
- R10: A pin change becomes visible in the flag after the third rising clock edge following the change.
- R11: req_nmi and req_irq[n] equal the corresponding status flags and are active high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_addr | input | 8 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from bus_addr |
| pin_nmi | input | 1 | Raw non-maskable input |
| pin_irq | input | 16 | Raw general interrupt pins |
| req_nmi | output | 1 | Non-maskable request to the parent |
| req_irq | output | 16 | Per-pin requests to the parent |

## Verification
The assertions assume that the pins are driven to a defined 0 or 1 on every cycle. They also assume that a write strobe lasts one clock and carries an address and data that are stable across that edge. The level-mode check further assumes that the synchronized pin stays low for as long as the flag is expected to hold. The stimulus meets these assumptions by holding every pin high while idle and changing pins and bus signals only on falling clock edges. It always drops the write strobe after one cycle. Pins are lowered only on purpose, and only for the source under test.

// File: rtl/ext_irq_sense.sv
module ext_irq_sense #(
  parameter int N_IRQ = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_we,
  input  logic [7:0]       bus_addr,
  input  logic [31:0]      bus_wdata,
  output logic [31:0]      bus_rdata,
  input  logic             pin_nmi,
  input  logic [N_IRQ-1:0] pin_irq,
  output logic             req_nmi,
  output logic [N_IRQ-1:0] req_irq
);
  localparam int SEL_W = 2 * N_IRQ;
  localparam logic [7:0] A_NSTAT = 8'h00, A_NCLR = 8'h04, A_NSEL = 8'h08;
  localparam logic [7:0] A_ISTAT = 8'h10, A_ICLR = 8'h14, A_ISEL = 8'h18;

  // synchronizer stages plus previous synced value; idle high
  logic [N_IRQ:0] s1, s2, s3;
  logic           nmi_sel, nmi_flag;
  logic [SEL_W-1:0] irq_sel;
  logic [N_IRQ-1:0] irq_flag, irq_hit, irq_next, clr_irq;
  logic           clr_nmi, nmi_hit;
  logic [N_IRQ:0] rise, fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '1;
      s2 <= '1;
      s3 <= '1;
    end else begin
      s1 <= {pin_nmi, pin_irq};
      s2 <= s1;
      s3 <= s2;
    end
  end

  assign rise = s2 & ~s3;
  assign fall = ~s2 & s3;

  assign clr_nmi = bus_we && (bus_addr == A_NCLR) && bus_wdata[0];
  assign clr_irq = (bus_we && bus_addr == A_ICLR) ? bus_wdata[N_IRQ-1:0] : '0;
  assign nmi_hit = nmi_sel ? rise[N_IRQ] : fall[N_IRQ];

  always_comb begin
    for (int n = 0; n < N_IRQ; n++) begin
      case (irq_sel[2*n +: 2])
        2'd1:    irq_hit[n] = fall[n];
        2'd2:    irq_hit[n] = rise[n];
        2'd3:    irq_hit[n] = rise[n] | fall[n];
        default: irq_hit[n] = 1'b0;
      endcase
      if (irq_sel[2*n +: 2] == 2'd0) irq_next[n] = ~s2[n];
      else irq_next[n] = irq_hit[n] | (irq_flag[n] & ~clr_irq[n]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_sel  <= 1'b0;
      irq_sel  <= '0;
      nmi_flag <= 1'b0;
      irq_flag <= '0;
    end else begin
      if (bus_we && bus_addr == A_NSEL) nmi_sel <= bus_wdata[0];
      if (bus_we && bus_addr == A_ISEL) irq_sel <= bus_wdata[SEL_W-1:0];
      nmi_flag <= nmi_hit | (nmi_flag & ~clr_nmi);
      irq_flag <= irq_next;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_NSTAT: bus_rdata[0] = nmi_flag;
      A_NSEL:  bus_rdata[0] = nmi_sel;
      A_ISTAT: bus_rdata[N_IRQ-1:0] = irq_flag;
      A_ISEL:  bus_rdata[SEL_W-1:0] = irq_sel;
      default: bus_rdata = '0;
    endcase
  end

  assign req_nmi = nmi_flag;
  assign req_irq = irq_flag;

  assert_nmi_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr_nmi && !nmi_hit) |-> !req_nmi);
  assert_nmi_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $past(nmi_flag && !clr_nmi) |-> req_nmi);

  for (genvar n = 0; n < N_IRQ; n++) begin : g_chk
    assert_edge_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $past(irq_flag[n] && irq_sel[2*n +: 2] != 2'd0 && !clr_irq[n]) |-> req_irq[n]);
    assert_edge_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $past(irq_hit[n] && clr_irq[n]) |-> req_irq[n]);
    assert_level_noclr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(irq_sel[2*n +: 2] == 2'd0 && clr_irq[n] && !s2[n]) |-> req_irq[n]);
  end
endmodule

// File: tb/ext_irq_sense_tb.sv
module ext_irq_sense_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  // {pin[3:0], mode[1:0], drive level, expected flag}
  localparam logic [7:0] VEC [NV] = '{
    {4'd0, 2'd1, 1'b0, 1'b1}, {4'd1, 2'd1, 1'b1, 1'b0},
    {4'd2, 2'd2, 1'b1, 1'b1}, {4'd3, 2'd2, 1'b0, 1'b0},
    {4'd4, 2'd3, 1'b0, 1'b1}, {4'd5, 2'd3, 1'b1, 1'b1},
    {4'd6, 2'd0, 1'b0, 1'b1}, {4'd7, 2'd0, 1'b1, 1'b0},
    {4'd15, 2'd3, 1'b1, 1'b1}, {4'd9, 2'd2, 1'b1, 1'b1}};

  logic clk = 0, rst_n = 0, bus_we = 0, pin_nmi = 1;
  logic [7:0] bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic [15:0] pin_irq = '1, req_irq;
  logic req_nmi;
  int checks = 0, fails = 0;
  logic [31:0] rv;

  ext_irq_sense u_dut (.clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_nmi(pin_nmi), .pin_irq(pin_irq),
    .req_nmi(req_nmi), .req_irq(req_irq));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);
    // R1 reset state
    rd(8'h00, rv); chk(rv == 0, "R1 nmi status", rv, 0);
    rd(8'h08, rv); chk(rv == 0, "R1 nmi sense", rv, 0);
    rd(8'h10, rv); chk(rv == 0, "R1 irq status", rv, 0);
    rd(8'h18, rv); chk(rv == 0, "R1 irq sense", rv, 0);
    chk(req_irq == 0 && !req_nmi, "R1 requests", {15'd0, req_nmi, req_irq}, 0);

    // R2 register readback
    wr(8'h18, 32'hE4E4_1B1B); rd(8'h18, rv); chk(rv == 32'hE4E4_1B1B, "R2 irq sense rb", rv, 32'hE4E4_1B1B);
    wr(8'h08, 32'h1); rd(8'h08, rv); chk(rv == 1, "R2 nmi sense rb", rv, 1);
    rd(8'h14, rv); chk(rv == 0, "R2 clear reads zero", rv, 0);
    wr(8'h08, 0);

    // R9 sense change alone sets nothing
    wr(8'h18, 32'hFFFF_FFFF); idle(5);
    rd(8'h10, rv); chk(rv == 0, "R9 no set on mode change", rv, 0);
    wr(8'h18, 32'h5555_5555); idle(5);
    rd(8'h10, rv); chk(rv == 0, "R9 no set on mode change 2", rv, 0);

    // R5 R7 R6 R11 vector table
    for (int v = 0; v < NV; v++) begin
      logic [3:0] p; logic [1:0] m; logic dv, ex;
      {p, m, dv, ex} = VEC[v];
      pin_irq = '1;
      wr(8'h18, 32'(m) << (2 * p));
      @(negedge clk) pin_irq[p] = ~dv;
      idle(5);
      wr(8'h14, 32'hFFFF);
      @(negedge clk) pin_irq[p] = dv;
      idle(4);
      rd(8'h10, rv);
      chk(rv == (32'(ex) << p), "R5 R7 R6 vector status", rv, 32'(ex) << p);
      chk(req_irq == 16'(32'(ex) << p), "R11 vector request", {16'd0, req_irq}, 32'(ex) << p);
    end
    pin_irq = '1;
    wr(8'h18, 0); idle(4);

    // R7 clear of an edge flag
    wr(8'h18, 32'(2'd1) << 0);
    @(negedge clk) pin_irq[0] = 0; idle(4);
    wr(8'h14, 32'h1);
    rd(8'h10, rv); chk(rv[0] == 0, "R7 edge flag cleared", rv, 0);
    @(negedge clk) pin_irq[0] = 1; idle(4);

    // R6 level flag ignores clear
    wr(8'h18, 0);
    @(negedge clk) pin_irq[3] = 0; idle(4);
    wr(8'h14, 32'h8);
    rd(8'h10, rv); chk(rv == 32'h8, "R6 clear ignored", rv, 32'h8);
    @(negedge clk) pin_irq[3] = 1; idle(4);
    rd(8'h10, rv); chk(rv == 0, "R6 auto clear", rv, 0);

    // R10 latency
    wr(8'h18, 32'(2'd2) << 4);
    @(negedge clk) pin_irq[2] = 1'b0; idle(4);
    @(negedge clk) pin_irq[2] = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(req_irq[2] == 0, "R10 not after two edges", {31'd0, req_irq[2]}, 0);
    @(negedge clk);
    chk(req_irq[2] == 1, "R10 set after third edge", {31'd0, req_irq[2]}, 1);

    // R8 edge beats simultaneous clear
    wr(8'h18, 32'(2'd3) << 8); wr(8'h14, 32'hFFFF);
    @(negedge clk) pin_irq[4] = 0;
    @(negedge clk);
    @(negedge clk) begin bus_we = 1; bus_addr = 8'h14; bus_wdata = 32'h10; end
    @(negedge clk) bus_we = 0;
    chk(req_irq[4] == 1, "R8 edge wins", {31'd0, req_irq[4]}, 1);
    wr(8'h14, 32'h10);
    chk(req_irq[4] == 0, "R8 later clear works", {31'd0, req_irq[4]}, 0);

    // R3 R4 non-maskable input
    @(negedge clk) pin_nmi = 0; idle(4);
    rd(8'h00, rv); chk(rv == 1, "R3 falling sets", rv, 1);
    chk(req_nmi == 1, "R11 nmi request", {31'd0, req_nmi}, 1);
    wr(8'h04, 1);
    rd(8'h00, rv); chk(rv == 0, "R4 clear", rv, 0);
    @(negedge clk) pin_nmi = 1; idle(4);
    rd(8'h00, rv); chk(rv == 0, "R3 rising ignored in falling mode", rv, 0);
    wr(8'h08, 1);
    @(negedge clk) pin_nmi = 0; idle(4);
    rd(8'h00, rv); chk(rv == 0, "R3 falling ignored in rising mode", rv, 0);
    @(negedge clk) pin_nmi = 1; idle(4);
    rd(8'h00, rv); chk(rv == 1, "R3 rising sets", rv, 1);
    wr(8'h04, 32'hFFFF_FFFE);
    rd(8'h00, rv); chk(rv == 1, "R4 bit0 only", rv, 1);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule